// File: doc/BRIEF.md
# Fractional-Rate Buffer Pointer Servo

This block runs the read side of a 256-entry circular sample buffer. The write side fills that buffer from an input stream whose clock is not the output clock. A write index moves forward by one for each accepted input sample. A read pointer in Q8.16 form (an 8-bit address and a 16-bit phase) moves forward by a Q16.16 stride on each output tick. A proportional-integral loop sets the stride so that the read pointer follows a target position. The target sits a configurable number of samples behind the write index.

The target position also carries a sub-sample part, so that a slow drift across one sample boundary appears as a smooth ramp and not as a step. A free-running cycle counter is sampled on every input sample and on every output tick. A sequential divider then turns the time since the last input into a fraction of the most recent input interval. The stride is the sum of three terms: a nominal rate supplied from outside, a shifted proportional term and a saturating integral term. When the read pointer reaches or overtakes the write index, the block reloads the read pointer to the target and raises a flag. A downstream interpolator uses the address and phase outputs.

Top module: `rate_servo`

## Requirements
- R1: While reset is low and on the first cycle after it, `rd_addr`, `rd_phase`, `wr_addr`, `rd_valid` and `slip` are zero and `stride` equals `nominal`.
- R2: Each cycle with `in_valid` high adds one to `wr_addr`, modulo 256. Cycles without it leave `wr_addr` unchanged.
- R3: At an accepted tick, the sub-sample fraction is computed from two quantities: E, the number of cycles from the last input sample to the tick, and I, the number of cycles between the last two input samples. The fraction is floor(E·65536/I). It is 65535 when E ≥ I, and 0 if fewer than two samples have arrived since reset.
- R4: The target is ((W − `delay`) mod 256)·65536 + fraction, where W is `wr_addr` at the tick. The error is (target − read pointer) mod 2^24, read as a signed 24-bit value.
- R5: The integrator becomes clamp(integrator + (error >>> `ki_shift`), ±`int_limit`). The new stride is clamp(`nominal` + (error >>> `kp_shift`) + integrator, 0, 2^32−1). Both shifts are arithmetic.
- R6: For each accepted tick, `rd_valid` pulses for exactly one cycle. In that same cycle, `stride` shows the new stride and {`rd_addr`,`rd_phase`} show the new read pointer. If there is no slip, the new pointer is (old pointer + stride) mod 2^24. The outputs hold their values between pulses.
- R7: If (W − new address) mod 256 is 0 or at least 128, `slip` pulses together with `rd_valid` and the read pointer is loaded with the target instead.
- R8: A tick that arrives while an earlier tick is still being processed is dropped and produces no result.
- R9: A reset in mid-run loads the current `nominal` into `stride` and clears the integrator, so the first update after reset uses a zero integral history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also drives the timestamp counter |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One input sample accepted this cycle |
| out_tick | input | 1 | Output sample tick |
| delay | input | 8 | Target distance behind the write index, in samples |
| nominal | input | 32 | Feedforward stride, Q16.16 |
| kp_shift | input | 5 | Proportional gain as a right shift |
| ki_shift | input | 5 | Integral gain as a right shift |
| int_limit | input | 31 | Integrator magnitude limit, Q16.16 |
| wr_addr | output | 8 | Write index |
| rd_addr | output | 8 | Integer read address |
| rd_phase | output | 16 | Fractional read phase |
| stride | output | 32 | Current stride, Q16.16 |
| rd_valid | output | 1 | Read pointer and stride updated this cycle |
| slip | output | 1 | Read pointer reached the write index and was reloaded |

## Verification
The checker relies on three conditions: `in_valid` and `out_tick` are never high on the same edge, configuration inputs change only while no tick is being processed, and `nominal` is stable through each reset. The stimulus meets all three. It issues input samples and ticks one at a time from sequential tasks, and it changes settings only after a tick's result has come back. The bench spaces ticks by more than the divider's run time. The one exception is the deliberate second tick used to show that busy ticks are dropped, which is placed where the long division is known to be running.

// File: rtl/psv_pkg.sv
// Shared definitions for the pointer servo.
// Assumes nothing beyond the 1800-2017 language.
package psv_pkg;
    // State of the sequential fraction divider.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/psv_frac_div.sv
// Sequential restoring divider that gives num/den as a FRAC_W-bit fraction.
// It handles two short cases in one cycle: with fewer than two samples or
// a zero den it returns 0, and with num >= den it returns the largest
// fraction. Any other start runs for FRAC_W cycles. done pulses once with quo valid.
module psv_frac_div
    import psv_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              have_two,
    input  logic [CNT_W-1:0]  num,
    input  logic [CNT_W-1:0]  den,
    output logic              busy,
    output logic              done,
    output logic [FRAC_W-1:0] quo
);
    localparam int CW = $clog2(FRAC_W + 1);

    div_state_e       st;
    logic [CNT_W-1:0] rem, den_r, diff;
    logic [CNT_W:0]   rem2;
    logic [CW-1:0]    left;
    logic             fits;

    // Trial subtraction for one quotient bit.
    always_comb begin
        rem2 = {rem, 1'b0};
        fits = (rem2 >= {1'b0, den_r});
        diff = rem2[CNT_W-1:0] - den_r;
    end

    // Division sequencer: the short cases finish at once, others shift FRAC_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= DIV_IDLE;
            done  <= 1'b0;
            quo   <= '0;
            rem   <= '0;
            den_r <= '0;
            left  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                DIV_IDLE: begin
                    if (start) begin
                        if (!have_two || den == '0) begin
                            quo  <= '0;
                            done <= 1'b1;
                        end else if (num >= den) begin
                            quo  <= '1;
                            done <= 1'b1;
                        end else begin
                            rem   <= num;
                            den_r <= den;
                            quo   <= '0;
                            left  <= CW'(FRAC_W);
                            st    <= DIV_RUN;
                        end
                    end
                end
                DIV_RUN: begin
                    rem  <= fits ? diff : rem2[CNT_W-1:0];
                    quo  <= {quo[FRAC_W-2:0], fits};
                    left <= left - CW'(1);
                    if (left == CW'(1)) begin
                        st   <= DIV_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= DIV_IDLE;
            endcase
        end
    end

    assign busy = (st == DIV_RUN);
endmodule

// File: rtl/psv_pi_loop.sv
// PI correction added to a feedforward stride.
// Gains are arithmetic right shifts. The integrator is clamped to
// +/-limit and advances only on upd. The stride output is combinational
// and clamped to the unsigned STR_W-bit range. Assumes ERR_W < STR_W.
module psv_pi_loop #(
    parameter int ERR_W = 24,
    parameter int STR_W = 32,
    parameter int SH_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [ERR_W-1:0] err,
    input  logic [STR_W-1:0]        nominal,
    input  logic [SH_W-1:0]         kp_shift,
    input  logic [SH_W-1:0]         ki_shift,
    input  logic [STR_W-2:0]        limit,
    output logic [STR_W-1:0]        stride_nxt
);
    localparam int W = STR_W + 2;

    logic signed [STR_W-1:0] integ;
    logic signed [W-1:0]     err_x, p_term, i_step, i_sum, lim_p, lim_n, i_sat, s_sum;

    // Proportional term, saturating integral and clamped stride sum.
    always_comb begin
        err_x  = {{(W-ERR_W){err[ERR_W-1]}}, err};
        p_term = err_x >>> kp_shift;
        i_step = err_x >>> ki_shift;
        i_sum  = {{2{integ[STR_W-1]}}, integ} + i_step;
        lim_p  = {3'b000, limit};
        lim_n  = -lim_p;
        if (i_sum > lim_p)      i_sat = lim_p;
        else if (i_sum < lim_n) i_sat = lim_n;
        else                    i_sat = i_sum;
        s_sum = {2'b00, nominal} + p_term + i_sat;
        if (s_sum[W-1])                   stride_nxt = '0;
        else if (s_sum[W-2:STR_W] != '0)  stride_nxt = '1;
        else                              stride_nxt = s_sum[STR_W-1:0];
    end

    // Integrator state: cleared by reset, updated once per servo step.
    always_ff @(posedge clk) begin
        if (!rst_n)   integ <= '0;
        else if (upd) integ <= i_sat[STR_W-1:0];
    end
endmodule

// File: rtl/rate_servo.sv
// Read-pointer servo for a circular sample buffer.
// It timestamps input samples and output ticks with a free-running counter,
// derives a sub-sample target behind the write index, and steps a Q8.16
// read pointer by a PI-corrected stride. Assumes in_valid and out_tick are
// synchronous to clk and never coincide. Ticks are dropped while a step runs.
module rate_servo
    import psv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int FRAC_W = 16,
    parameter int STR_W  = 32,
    parameter int CNT_W  = 32,
    parameter int SH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_tick,
    input  logic [ADDR_W-1:0] delay,
    input  logic [STR_W-1:0]  nominal,
    input  logic [SH_W-1:0]   kp_shift,
    input  logic [SH_W-1:0]   ki_shift,
    input  logic [STR_W-2:0]  int_limit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [FRAC_W-1:0] rd_phase,
    output logic [STR_W-1:0]  stride,
    output logic              rd_valid,
    output logic              slip
);
    localparam int PTR_W = ADDR_W + FRAC_W;

    logic [CNT_W-1:0]        cyc_cnt, t_last, t_prev;
    logic [1:0]              seen;
    logic [ADDR_W-1:0]       wr_ptr, wr_snap, sp_int, gap;
    logic [PTR_W-1:0]        rd_ptr, set_pt, rd_adv;
    logic signed [PTR_W-1:0] err_s;
    logic [STR_W-1:0]        stride_nxt;
    logic [FRAC_W-1:0]       div_quo;
    logic                    div_busy, div_done, accept, slip_c;

    // Free-running timestamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_cnt <= '0;
        else        cyc_cnt <= cyc_cnt + CNT_W'(1);
    end

    // Write index and the two most recent input timestamps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            t_last <= '0;
            t_prev <= '0;
            seen   <= '0;
        end else if (in_valid) begin
            wr_ptr <= wr_ptr + ADDR_W'(1);
            t_prev <= t_last;
            t_last <= cyc_cnt;
            seen   <= (seen == 2'd2) ? 2'd2 : seen + 2'd1;
        end
    end

    assign accept = out_tick && !div_busy && !div_done;

    // Capture the write index seen by an accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_snap <= '0;
        else if (accept) wr_snap <= wr_ptr;
    end

    psv_frac_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .have_two (seen[1]),
        .num      (cyc_cnt - t_last),
        .den      (t_last - t_prev),
        .busy     (div_busy),
        .done     (div_done),
        .quo      (div_quo)
    );

    // Target position, wrap-aware error, advanced pointer and slip test.
    always_comb begin
        sp_int = wr_snap - delay;
        set_pt = {sp_int, div_quo};
        err_s  = set_pt - rd_ptr;
        rd_adv = rd_ptr + stride_nxt[PTR_W-1:0];
        gap    = wr_snap - rd_adv[PTR_W-1:FRAC_W];
        slip_c = (gap == '0) || gap[ADDR_W-1];
    end

    psv_pi_loop #(.ERR_W(PTR_W), .STR_W(STR_W), .SH_W(SH_W)) u_pi (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (div_done),
        .err        (err_s),
        .nominal    (nominal),
        .kp_shift   (kp_shift),
        .ki_shift   (ki_shift),
        .limit      (int_limit),
        .stride_nxt (stride_nxt)
    );

    // Read pointer and stride registers, stepped once per finished division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            stride   <= nominal;
            rd_valid <= 1'b0;
            slip     <= 1'b0;
        end else begin
            rd_valid <= div_done;
            slip     <= div_done && slip_c;
            if (div_done) begin
                stride <= stride_nxt;
                rd_ptr <= slip_c ? set_pt : rd_adv;
            end
        end
    end

    assign wr_addr  = wr_ptr;
    assign rd_addr  = rd_ptr[PTR_W-1:FRAC_W];
    assign rd_phase = rd_ptr[FRAC_W-1:0];
endmodule

// File: rtl/rate_servo_chk.sv
// Temporal checks on the ports of rate_servo, attached by bind.
// Assumes nominal is stable while reset is held.
module rate_servo_chk #(
    parameter int ADDR_W = 8,
    parameter int FRAC_W = 16,
    parameter int STR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [STR_W-1:0]  nominal,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [FRAC_W-1:0] rd_phase,
    input logic [STR_W-1:0]  stride,
    input logic              rd_valid,
    input logic              slip
);
    // R2: one step per accepted input sample
    a_r2_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_addr == $past(wr_addr) + ADDR_W'(1));

    // R2: no input sample, no movement
    a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_addr));

    // R6: read side changes only together with rd_valid
    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable({rd_addr, rd_phase, stride}));

    // R7: slip is only reported with an update
    a_r7_slip_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> rd_valid);

    // R8: updates never come back to back
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9: leaving reset, the stride equals nominal and the pointer is zero
    a_r9_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stride == nominal && rd_addr == '0 && rd_phase == '0));
endmodule

bind rate_servo rate_servo_chk #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .STR_W(STR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .nominal  (nominal),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .rd_phase (rd_phase),
    .stride   (stride),
    .rd_valid (rd_valid),
    .slip     (slip)
);

// File: tb/rate_servo_bench.sv
// Scoreboard bench: the tick task predicts each update from the
// requirements and queues it, and a monitor pops and compares on rd_valid.
module rate_servo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_tick = 1'b0;
    logic [7:0]  delay = 8'd16;
    logic [31:0] nominal = 32'h0001_0000;
    logic [4:0]  kp_shift = 5'd2;
    logic [4:0]  ki_shift = 5'd6;
    logic [30:0] int_limit = 31'h4000;
    logic [7:0]  wr_addr, rd_addr;
    logic [15:0] rd_phase;
    logic [31:0] stride;
    logic        rd_valid, slip;

    rate_servo u_rate_servo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_tick(out_tick),
        .delay(delay), .nominal(nominal), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .int_limit(int_limit), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_phase(rd_phase),
        .stride(stride), .rd_valid(rd_valid), .slip(slip)
    );

    always #4 clk = ~clk;

    typedef struct {
        longint a;
        longint ph;
        longint st;
        longint sl;
    } exp_t;

    exp_t   q[$];
    longint cyc = 0;
    int     n_checks = 0;
    int     n_fail = 0;
    bit     finished = 1'b0;
    longint m_rd, m_integ, m_wr, m_nin, t_last, t_prev;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rd = 0; m_integ = 0; m_wr = 0; m_nin = 0; t_last = 0; t_prev = 0;
    endtask

    task automatic in_sample();
        @(negedge clk);
        in_valid = 1'b1;
        t_prev = t_last;
        t_last = cyc;
        m_nin++;
        m_wr++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Predict one servo step from the requirements (R3, R4, R5, R6, R7).
    task automatic predict(longint tcur);
        exp_t   e;
        longint frac, sp, er, p, isum, s, adv, gap, el, iv;
        if (m_nin < 2) frac = 0;                       // R3 too few samples
        else begin
            el = tcur - t_last;
            iv = t_last - t_prev;
            if (iv == 0)        frac = 0;
            else if (el >= iv)  frac = 65535;          // R3 clamp
            else                frac = (el * 65536) / iv;
        end
        sp = (((m_wr - longint'(delay)) & 255) << 16) + frac;   // R4 target
        er = (sp - m_rd) & 64'hFFFFFF;
        if (er >= 64'h800000) er = er - 64'h1000000;
        p    = er >>> kp_shift;                        // R5
        isum = m_integ + (er >>> ki_shift);
        if (isum > longint'(int_limit))  isum = longint'(int_limit);
        if (isum < -longint'(int_limit)) isum = -longint'(int_limit);
        s = longint'(nominal) + p + isum;
        if (s < 0) s = 0;
        if (s > 64'hFFFF_FFFF) s = 64'hFFFF_FFFF;
        adv = (m_rd + (s & 64'hFFFFFF)) & 64'hFFFFFF;  // R6
        gap = (m_wr - (adv >> 16)) & 255;
        e.sl = (gap == 0 || gap >= 128) ? 1 : 0;        // R7
        m_rd = (e.sl != 0) ? sp : adv;
        m_integ = isum;
        e.a = m_rd >> 16;
        e.ph = m_rd & 16'hFFFF;
        e.st = s;
        q.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
        predict(cyc);
        out_tick = 1'b1;
        @(negedge clk);
        out_tick = 1'b0;
        repeat (24) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R1", "rd_addr", longint'(rd_addr), 0);
        chk("R1", "rd_phase", longint'(rd_phase), 0);
        chk("R1", "wr_addr", longint'(wr_addr), 0);
        chk("R1", "rd_valid", longint'(rd_valid), 0);
        chk("R1", "slip", longint'(slip), 0);
        chk("R9", "stride after reset", longint'(stride), longint'(nominal));
    endtask

    // Monitor: compare each update against the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8 unexpected update: actual 1 expected 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R6", "rd_addr", longint'(rd_addr), e.a);
                chk("R6", "rd_phase", longint'(rd_phase), e.ph);
                chk("R5", "stride", longint'(stride), e.st);
                chk("R7", "slip", longint'(slip), e.sl);
            end
        end
    end

    initial begin
        model_reset();
        do_reset();                               // R1
        tick();                                   // R3: no samples yet, fraction 0
        for (int i = 0; i < 40; i++) begin
            in_sample();
            repeat (8) @(negedge clk);
        end
        chk("R2", "wr_addr after 40", longint'(wr_addr), 40);
        for (int i = 0; i < 20; i++) begin        // R3 and R4 at varied phases
            in_sample();
            repeat ((i * 7) % 23) @(negedge clk);
            tick();
        end
        in_sample();                              // R3 clamp: elapsed beyond interval
        repeat (3) @(negedge clk);
        in_sample();
        repeat (10) @(negedge clk);
        tick();
        in_sample();                              // R8: a second tick while dividing
        repeat (20) @(negedge clk);
        in_sample();
        repeat (5) @(negedge clk);
        predict(cyc + 1);
        @(negedge clk); out_tick = 1'b1;
        @(negedge clk); out_tick = 1'b0;
        repeat (3) @(negedge clk);
        out_tick = 1'b1;
        @(negedge clk); out_tick = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8", "queue after dropped tick", longint'(q.size()), 0);
        ki_shift = 5'd0; int_limit = 31'h100;     // R5 integrator saturation
        for (int i = 0; i < 3; i++) begin
            in_sample(); repeat (4) @(negedge clk); tick();
        end
        delay = 8'd0; kp_shift = 5'd0; ki_shift = 5'd31;   // R7 slip and reload
        for (int i = 0; i < 3; i++) begin
            in_sample(); repeat (6) @(negedge clk); tick();
        end
        delay = 8'd100; nominal = 32'h0000_0100;  // R5 stride clamp at zero
        in_sample(); repeat (6) @(negedge clk); tick();
        for (int i = 0; i < 300; i++) in_sample();   // R2 wrap
        chk("R2", "wr_addr wrap", longint'(wr_addr), m_wr & 255);
        delay = 8'd16; kp_shift = 5'd3; ki_shift = 5'd5; int_limit = 31'h8000;
        nominal = 32'h0001_2000;                  // R9 mid-run reset
        do_reset();
        in_sample(); repeat (9) @(negedge clk);
        in_sample(); repeat (4) @(negedge clk);
        tick();
        tick();
        chk("R6", "pending predictions", longint'(q.size()), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule